// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Teaching Processor

This block is a small processor for a sixteen-operation teaching instruction set. It has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It is tied to a private 256-byte memory over an 8-bit bus. Each instruction is one 16-bit word held in two neighbouring bytes. The high byte is at the program counter and the low byte is at the next address. Because the bus is byte-wide, every instruction takes two memory reads. A decode cycle then latches the operand registers, and an execute cycle commits the result. Each instruction therefore lasts four clock cycles.

The top nibble of an instruction is the opcode. The three nibbles below it name registers, a shift count, or together form an 8-bit constant or memory address. A program is placed in memory through a side port while reset is held. Execution starts at address 0 when reset is released. The program runs until a halt instruction raises the halted flag. The side port then reads the results back from memory.

Top module: `byte_cpu`

## Requirements
- R1: While reset is low, halted is 0. Leaving reset sets the program counter and all sixteen registers to 0, and memory keeps its contents.
- R2: The instruction word is built from two reads. The high byte comes from address PC and the low byte from PC+1. The program counter then advances by 2. Execution starts at address 0, and every instruction takes 4 cycles, so a program of k executed instructions ending in halt raises halted after the 4k-th rising edge.
- R3: Opcode 0x1 (word 1 A hh) loads register A from memory byte hh. Opcode 0x2 (word 2 A hh) loads register A with the constant hh.
- R4: Opcode 0x3 (word 3 A hh) writes register A to memory byte hh. No other opcode writes memory.
- R5: Opcode 0x4 (word 4 x S D) copies register S into register D.
- R6: Opcode 0x5 (word 5 A B C) sets register A to B + C modulo 256.
- R7: Opcodes 0x7, 0x8 and 0x9 (word op A B C) set register A to B OR C, B AND C and B XOR C respectively.
- R8: Opcode 0xA (word A A x N) rotates register A right by N mod 8 bit positions.
- R9: Opcode 0xB (word B A hh) loads hh into the program counter when register A equals register 0. Otherwise execution continues with the next word.
- R10: Opcode 0xC halts. Halted then stays 1 until reset, and the program counter, registers and memory stop changing.
- R11: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF change no register and no memory byte, and execution continues.
- R12: A write on the side port stores tb_mem_wdata at tb_mem_addr on the rising edge while tb_mem_we is 1. tb_mem_rdata always shows the byte at tb_mem_addr. A store from the processor in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| halted | output | 1 | High once a halt instruction has executed |
| tb_mem_we | input | 1 | Side-port write enable |
| tb_mem_addr | input | 8 | Side-port byte address |
| tb_mem_wdata | input | 8 | Side-port write data |
| tb_mem_rdata | output | 8 | Side-port read data, combinational |

## Verification
Registers are invisible at the ports, so a wrong register value shows up only when a later store writes it to memory. Each program therefore ends by storing the registers it touched, and the results are read back after halted rises. A wrong sequencing state or program counter shows up in the cycle at which halted rises, which is checked against 4 cycles per executed instruction. It also shows up as missing stores when a jump goes to the wrong word. Corruption after halt is caught by waiting further cycles and confirming that a store placed after the halt word never lands.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_REGS = 16;
  localparam int SEL_W = $clog2(NUM_REGS);
  localparam int INSN_W = 2 * DATA_W;
  localparam int ROT_W = $clog2(DATA_W);

  localparam logic [3:0] OP_LDM  = 4'h1;
  localparam logic [3:0] OP_LDI  = 4'h2;
  localparam logic [3:0] OP_STO  = 4'h3;
  localparam logic [3:0] OP_MOV  = 4'h4;
  localparam logic [3:0] OP_ADD  = 4'h5;
  localparam logic [3:0] OP_FADD = 4'h6;
  localparam logic [3:0] OP_OR   = 4'h7;
  localparam logic [3:0] OP_AND  = 4'h8;
  localparam logic [3:0] OP_XOR  = 4'h9;
  localparam logic [3:0] OP_ROT  = 4'hA;
  localparam logic [3:0] OP_JEQ  = 4'hB;
  localparam logic [3:0] OP_HLT  = 4'hC;

  typedef enum logic [2:0] {
    PH_FHI  = 3'd0,
    PH_FLO  = 3'd1,
    PH_DEC  = 3'd2,
    PH_EXE  = 3'd3,
    PH_HALT = 3'd4
  } phase_t;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_logic(input logic [3:0] op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      default: r = a ^ b;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] f_rotr(input logic [DATA_W-1:0] v,
                                                input logic [ROT_W-1:0] amt);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) begin
      r[i] = v[(i + int'(amt)) % DATA_W];
    end
    return r;
  endfunction

  function automatic logic writes_reg(input logic [3:0] op);
    return (op == OP_LDM) || (op == OP_LDI) || (op == OP_MOV) || (op == OP_ADD) ||
           (op == OP_OR) || (op == OP_AND) || (op == OP_XOR) || (op == OP_ROT);
  endfunction
endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          side_we,
  input  logic [DW-1:0] side_addr,
  input  logic [DW-1:0] side_wdata,
  output logic [DW-1:0] side_rdata
);
  localparam int DEPTH = 1 << DW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (cpu_we) begin
      cells[cpu_addr] <= cpu_wdata;
    end else if (side_we) begin
      cells[side_addr] <= side_wdata;
    end
  end

  assign cpu_rdata  = cells[cpu_addr];
  assign side_rdata = cells[side_addr];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DW = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr_x,
  input  logic [$clog2(NREG)-1:0] raddr_y,
  output logic [DW-1:0]           rdata_x,
  output logic [DW-1:0]           rdata_y
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (int'(waddr) == g)) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata_x = regs[raddr_x];
  assign rdata_y = regs[raddr_y];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [SEL_W-1:0]    rsel_x,
  output logic [SEL_W-1:0]    rsel_y,
  input  logic [DATA_W-1:0]   rval_x,
  input  logic [DATA_W-1:0]   rval_y,
  output logic                rf_we,
  output logic [SEL_W-1:0]    rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic                halted,
  output phase_t              phase,
  output logic [DATA_W-1:0]   pc,
  output logic [INSN_W-1:0]   ir,
  output logic                jump_taken
);
  phase_t            phase_q, phase_d;
  logic [DATA_W-1:0] pc_q;
  logic [INSN_W-1:0] ir_q;
  logic [DATA_W-1:0] opx_q, opy_q;

  logic [3:0]        op;
  logic [SEL_W-1:0]  fa, fb, fc;
  logic [DATA_W-1:0] imm;

  assign op  = ir_q[INSN_W-1 -: 4];
  assign fa  = ir_q[3*SEL_W-1 -: SEL_W];
  assign fb  = ir_q[2*SEL_W-1 -: SEL_W];
  assign fc  = ir_q[SEL_W-1:0];
  assign imm = ir_q[DATA_W-1:0];

  // operand selection for the decode cycle
  always_comb begin
    rsel_x = fa;
    rsel_y = fc;
    case (op)
      OP_MOV, OP_ADD, OP_OR, OP_AND, OP_XOR: rsel_x = fb;
      OP_JEQ:                                rsel_y = '0;
      default: ;
    endcase
  end

  // bus address per phase
  always_comb begin
    case (phase_q)
      PH_FHI:  mem_addr = pc_q;
      PH_FLO:  mem_addr = pc_q + DATA_W'(1);
      default: mem_addr = imm;
    endcase
  end

  // execute-cycle effects
  always_comb begin
    rf_we      = 1'b0;
    rf_waddr   = (op == OP_MOV) ? fc : fa;
    rf_wdata   = opx_q;
    mem_we     = 1'b0;
    mem_wdata  = opx_q;
    jump_taken = 1'b0;
    if (phase_q == PH_EXE) begin
      rf_we  = writes_reg(op);
      mem_we = (op == OP_STO);
      jump_taken = (op == OP_JEQ) && (opx_q == opy_q);
      case (op)
        OP_LDM:                rf_wdata = mem_rdata;
        OP_LDI:                rf_wdata = imm;
        OP_ADD:                rf_wdata = f_add(opx_q, opy_q);
        OP_OR, OP_AND, OP_XOR: rf_wdata = f_logic(op, opx_q, opy_q);
        OP_ROT:                rf_wdata = f_rotr(opx_q, fc[ROT_W-1:0]);
        default:               rf_wdata = opx_q;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_FHI:  phase_d = PH_FLO;
      PH_FLO:  phase_d = PH_DEC;
      PH_DEC:  phase_d = PH_EXE;
      PH_EXE:  phase_d = (op == OP_HLT) ? PH_HALT : PH_FHI;
      default: phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FHI;
      pc_q    <= '0;
      ir_q    <= '0;
      opx_q   <= '0;
      opy_q   <= '0;
    end else begin
      phase_q <= phase_d;
      case (phase_q)
        PH_FHI: ir_q[INSN_W-1:DATA_W] <= mem_rdata;
        PH_FLO: begin
          ir_q[DATA_W-1:0] <= mem_rdata;
          pc_q <= pc_q + DATA_W'(2);
        end
        PH_DEC: begin
          opx_q <= rval_x;
          opy_q <= rval_y;
        end
        PH_EXE: if (jump_taken) pc_q <= imm;
        default: ;
      endcase
    end
  end

  assign halted = (phase_q == PH_HALT);
  assign phase  = phase_q;
  assign pc     = pc_q;
  assign ir     = ir_q;
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              halted,
  input  logic              tb_mem_we,
  input  logic [DATA_W-1:0] tb_mem_addr,
  input  logic [DATA_W-1:0] tb_mem_wdata,
  output logic [DATA_W-1:0] tb_mem_rdata
);
  logic [DATA_W-1:0] bus_addr, bus_rdata, bus_wdata;
  logic              bus_we;
  logic [SEL_W-1:0]  rsel_x, rsel_y, rf_waddr;
  logic [DATA_W-1:0] rval_x, rval_y, rf_wdata;
  logic              rf_we;
  phase_t            phase;
  logic [DATA_W-1:0] pc;
  logic [INSN_W-1:0] ir;
  logic              jump_taken;

  cpu_mem #(.DW(DATA_W)) mem_i (
    .clk        (clk),
    .cpu_we     (bus_we),
    .cpu_addr   (bus_addr),
    .cpu_wdata  (bus_wdata),
    .cpu_rdata  (bus_rdata),
    .side_we    (tb_mem_we),
    .side_addr  (tb_mem_addr),
    .side_wdata (tb_mem_wdata),
    .side_rdata (tb_mem_rdata)
  );

  cpu_regfile #(.DW(DATA_W), .NREG(NUM_REGS)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_x (rsel_x),
    .raddr_y (rsel_y),
    .rdata_x (rval_x),
    .rdata_y (rval_y)
  );

  cpu_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rdata  (bus_rdata),
    .mem_addr   (bus_addr),
    .mem_we     (bus_we),
    .mem_wdata  (bus_wdata),
    .rsel_x     (rsel_x),
    .rsel_y     (rsel_y),
    .rval_x     (rval_x),
    .rval_y     (rval_y),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .halted     (halted),
    .phase      (phase),
    .pc         (pc),
    .ir         (ir),
    .jump_taken (jump_taken)
  );
endmodule

// File: rtl/byte_cpu_chk.sv
module byte_cpu_chk
  import cpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input phase_t            phase,
  input logic [DATA_W-1:0] pc,
  input logic [INSN_W-1:0] ir,
  input logic              rf_we,
  input logic              mem_we,
  input logic              jump_taken
);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLO) |=> (pc == $past(pc) + DATA_W'(2)));

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> (pc == $past(ir[DATA_W-1:0])));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!rf_we && !mem_we));

  // R4
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((phase == PH_EXE) && (ir[INSN_W-1 -: 4] == OP_STO)));

  // R11
  ignored_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_EXE) && ((ir[INSN_W-1 -: 4] == 4'h0) || (ir[INSN_W-1 -: 4] == OP_FADD) ||
      (ir[INSN_W-1 -: 4] > OP_HLT))) |-> (!rf_we && !mem_we));

  // R2
  one_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rf_we, mem_we, jump_taken}) <= 1);
endmodule

bind byte_cpu byte_cpu_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .halted     (halted),
  .phase      (phase),
  .pc         (pc),
  .ir         (ir),
  .rf_we      (rf_we),
  .mem_we     (bus_we),
  .jump_taken (jump_taken)
);

// File: tb/byte_cpu_tb_top.sv
module byte_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halted;
  logic       tb_mem_we = 1'b0;
  logic [7:0] tb_mem_addr = 8'h00;
  logic [7:0] tb_mem_wdata = 8'h00;
  logic [7:0] tb_mem_rdata;

  int checks = 0;
  int fails = 0;
  int wd_cycles = 0;

  always #2 clk = ~clk;

  byte_cpu dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .halted       (halted),
    .tb_mem_we    (tb_mem_we),
    .tb_mem_addr  (tb_mem_addr),
    .tb_mem_wdata (tb_mem_wdata),
    .tb_mem_rdata (tb_mem_rdata)
  );

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired (R2 run never ended): actual %0d cycles, expected fewer", wd_cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h, expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic mem_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tb_mem_we = 1'b1;
    tb_mem_addr = a;
    tb_mem_wdata = d;
    @(posedge clk);
    #1 tb_mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    tb_mem_addr = a;
    #1 d = tb_mem_rdata;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    mem_wr(a, w[15:8]);
    mem_wr(a + 8'd1, w[7:0]);
  endtask

  // hold reset and zero the memory
  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem_wr(8'(i), 8'h00);
  endtask

  task automatic run_prog(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic expect_mem(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    mem_rd(a, d);
    chk(tag, int'(d), int'(exp));
  endtask

  task automatic t_preload();
    logic [7:0] d;
    begin_test();
    mem_wr(8'hFE, 8'hA5);
    mem_wr(8'h03, 8'h3C);
    mem_rd(8'hFE, d);
    chk("R12 side-port readback 0xFE", int'(d), 8'hA5);
    mem_rd(8'h03, d);
    chk("R12 side-port readback 0x03", int'(d), 8'h3C);
  endtask

  task automatic t_reset();
    int cyc;
    begin_test();
    chk("R1 halted low in reset", int'(halted), 0);
    put(8'h00, 16'h3780);
    put(8'h02, 16'h3F81);
    put(8'h04, 16'hC000);
    mem_wr(8'h80, 8'hAA);
    mem_wr(8'h81, 8'hBB);
    run_prog(cyc);
    chk("R2 cycles for 3 instructions", cyc, 12);
    expect_mem("R1 R7 zero after reset", 8'h80, 8'h00);
    expect_mem("R1 R15 zero after reset", 8'h81, 8'h00);
  endtask

  task automatic t_sum();
    int cyc;
    begin_test();
    put(8'h00, 16'h156C);
    put(8'h02, 16'h166D);
    put(8'h04, 16'h5056);
    put(8'h06, 16'h306E);
    put(8'h08, 16'hC000);
    mem_wr(8'h6C, 8'h35);
    mem_wr(8'h6D, 8'hD4);
    run_prog(cyc);
    chk("R2 cycles for 5 instructions", cyc, 20);
    expect_mem("R6 wrapped sum stored (R3 R4)", 8'h6E, 8'h09);
    expect_mem("R4 source byte untouched", 8'h6C, 8'h35);
  endtask

  task automatic t_imm_move();
    int cyc;
    begin_test();
    put(8'h00, 16'h2A5C);
    put(8'h02, 16'h40A3);
    put(8'h04, 16'h3390);
    put(8'h06, 16'h3A91);
    put(8'h08, 16'hC000);
    run_prog(cyc);
    expect_mem("R5 move RA into R3", 8'h90, 8'h5C);
    expect_mem("R3 load constant into RA", 8'h91, 8'h5C);
  endtask

  task automatic t_logic();
    int cyc;
    begin_test();
    put(8'h00, 16'h21C3);
    put(8'h02, 16'h225A);
    put(8'h04, 16'h7312);
    put(8'h06, 16'h8412);
    put(8'h08, 16'h9512);
    put(8'h0A, 16'h33A0);
    put(8'h0C, 16'h34A1);
    put(8'h0E, 16'h35A2);
    put(8'h10, 16'hC000);
    run_prog(cyc);
    expect_mem("R7 OR", 8'hA0, 8'hDB);
    expect_mem("R7 AND", 8'hA1, 8'h42);
    expect_mem("R7 XOR", 8'hA2, 8'h99);
  endtask

  task automatic t_rotate();
    int cyc;
    begin_test();
    put(8'h00, 16'h2196);
    put(8'h02, 16'hA103);
    put(8'h04, 16'h2296);
    put(8'h06, 16'hA200);
    put(8'h08, 16'h2396);
    put(8'h0A, 16'hA30B);
    put(8'h0C, 16'h31B0);
    put(8'h0E, 16'h32B1);
    put(8'h10, 16'h33B2);
    put(8'h12, 16'hC000);
    run_prog(cyc);
    expect_mem("R8 rotate right 3", 8'hB0, 8'hD2);
    expect_mem("R8 rotate right 0", 8'hB1, 8'h96);
    expect_mem("R8 rotate right 11 mod 8", 8'hB2, 8'hD2);
  endtask

  task automatic t_jump();
    int cyc;
    begin_test();
    put(8'h00, 16'h2005);
    put(8'h02, 16'h2105);
    put(8'h04, 16'h2207);
    put(8'h06, 16'hB20C);
    put(8'h08, 16'h2311);
    put(8'h0A, 16'hB110);
    put(8'h0C, 16'h2399);
    put(8'h0E, 16'hC000);
    put(8'h10, 16'h33C0);
    put(8'h12, 16'hC000);
    run_prog(cyc);
    chk("R9 cycles with one taken jump", cyc, 32);
    expect_mem("R9 not-taken falls through, taken skips", 8'hC0, 8'h11);
  endtask

  task automatic t_ignored();
    int cyc;
    begin_test();
    mem_wr(8'h12, 8'h77);
    put(8'h00, 16'h2142);
    put(8'h02, 16'h2255);
    put(8'h04, 16'h6112);
    put(8'h06, 16'h0112);
    put(8'h08, 16'hD112);
    put(8'h0A, 16'hE112);
    put(8'h0C, 16'hF112);
    put(8'h0E, 16'h31D0);
    put(8'h10, 16'h32D1);
    put(8'h12, 16'hC000);
    run_prog(cyc);
    chk("R11 ignored opcodes still take 4 cycles", cyc, 40);
    expect_mem("R11 R1 unchanged", 8'hD0, 8'h42);
    expect_mem("R11 R2 unchanged", 8'hD1, 8'h55);
  endtask

  task automatic t_halt();
    int cyc;
    begin_test();
    mem_wr(8'h50, 8'hEE);
    put(8'h00, 16'h2177);
    put(8'h02, 16'hC000);
    put(8'h04, 16'h3150);
    run_prog(cyc);
    chk("R10 halted raised", int'(halted), 1);
    repeat (40) @(negedge clk);
    chk("R10 halted still high", int'(halted), 1);
    expect_mem("R10 no store after halt", 8'h50, 8'hEE);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 reset clears halted", int'(halted), 0);
    put(8'h00, 16'h3151);
    put(8'h02, 16'hC000);
    mem_wr(8'h51, 8'hCC);
    run_prog(cyc);
    expect_mem("R1 reset cleared R1", 8'h51, 8'h00);
    expect_mem("R1 memory kept across reset", 8'h50, 8'hEE);
  endtask

  initial begin
    t_preload();
    t_reset();
    t_sum();
    t_imm_move();
    t_logic();
    t_rotate();
    t_jump();
    t_ignored();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule